// File: doc/BRIEF.md
# Strobed Handshake Port

This block is a single 8-bit port that moves data in one direction at a time under a two-wire handshake. The direction is picked by a level input: in receive mode a peripheral pulls a low-active strobe to load its data into a holding latch, the block raises a buffer-full flag and, once the strobe ends, may raise an interrupt so that the CPU comes and reads the byte. In transmit mode the CPU writes a byte, the block drops a low-active buffer-full flag toward the peripheral, and a low-active acknowledge from the peripheral releases the flag and may raise an interrupt asking the CPU for the next byte.

All strobes are sampled on the system clock and every result is registered, so each handshake edge acts one clock after it is first sampled. An interrupt-enable flop, set and cleared by separate pulses, gates the interrupt. A 3-bit status word reports enable, flag level and interrupt for a CPU status read. In the surrounding chip the flag, interrupt and strobe are carried on dedicated pins of a shared control port: for the upper group the receive strobe, flag and interrupt sit on bits 4, 5 and 3, the transmit flag and acknowledge on bits 7 and 6 with the interrupt on bit 3; for the lower group strobe or acknowledge is bit 2, flag bit 1, interrupt bit 0. That multiplexing lives outside this block.

Top module: `hs_port`

## Requirements
- R1: While reset is asserted and after its release, `rdata` and `per_dout` are 0, the interrupt enable is clear, `intr` is 0 and `flag` is idle: 0 in receive mode (`mode_out`=0), 1 in transmit mode (`mode_out`=1).
- R2: In receive mode, every clock at which `per_hs_n` is sampled low loads `per_din` into the receive latch; `rdata` shows the latch one clock later and holds it while the strobe is high.
- R3: In receive mode, `flag` (active high) goes to 1 one clock after a falling edge of `per_hs_n` is sampled and goes to 0 one clock after a rising edge of `cpu_rd_n` is sampled; a strobe fall wins over a simultaneous read rise.
- R4: In receive mode, `intr` goes to 1 one clock after a rising edge of `per_hs_n` is sampled if the flag is 1 and the enable is set at that clock, and goes to 0 one clock after a falling edge of `cpu_rd_n`; the clear wins.
- R5: In transmit mode, every clock at which `cpu_wr_n` is sampled low loads `cpu_wdata` into the transmit latch, shown on `per_dout` one clock later; `per_oe` equals `mode_out` at all times.
- R6: In transmit mode, `flag` (active low) goes to 0 one clock after a rising edge of `cpu_wr_n` and to 1 one clock after a falling edge of `per_hs_n` (acknowledge); the write wins over a simultaneous acknowledge.
- R7: In transmit mode, `intr` goes to 1 one clock after a rising edge of `per_hs_n` if the flag is 1 (buffer empty) and the enable is set, and goes to 0 one clock after a falling edge of `cpu_wr_n`; the clear wins.
- R8: A pulse on `ie_set` sets the enable and one on `ie_clr` clears it (clear wins), one clock later; clearing the enable drives `intr` to 0 in the same clock while the flag keeps operating, and with the enable clear no interrupt is raised.
- R9: `status` bit 2 is the enable, bit 1 the current `flag` level, bit 0 the `intr` level.
- R10: A change of `mode_out`, sampled at a clock, reinitialises the port one clock later: both latches 0, enable clear, `intr` 0, `flag` idle for the new mode; handshake edges seen in that clock are dropped.
- R11: The CPU strobe of the other direction is ignored: in receive mode a `cpu_wr_n` pulse leaves `flag`, `intr` and `per_dout` unchanged; in transmit mode a `cpu_rd_n` pulse leaves `flag` and `intr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_out | input | 1 | 0 receive, 1 transmit |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_wdata | input | 8 | CPU write data |
| ie_set | input | 1 | Interrupt-enable set pulse |
| ie_clr | input | 1 | Interrupt-enable clear pulse |
| per_hs_n | input | 1 | Peripheral strobe (receive) or acknowledge (transmit), active low |
| per_din | input | 8 | Peripheral data in |
| per_dout | output | 8 | Transmit latch toward the peripheral |
| per_oe | output | 1 | Drive enable for the peripheral data pins |
| rdata | output | 8 | Receive latch toward the CPU |
| flag | output | 1 | Buffer-full flag (active high receive, active low transmit) |
| intr | output | 1 | Interrupt request |
| status | output | 3 | {enable, flag, intr} |

## Verification
Every registered result (latches, flag, enable, interrupt, status) is due exactly one clock after the clock edge at which its causing input level is first sampled; only `per_oe` follows `mode_out` with no delay. The bench changes inputs 2 ns after a rising edge, so the next rising edge samples them, and reads outputs 2 ns after that following edge and again at each falling edge against a behavioural model advanced on the same rising edges. Directed checks therefore read the result one clock after the stimulus, never in the stimulus cycle.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

    typedef enum logic {
        HS_DIR_IN  = 1'b0,
        HS_DIR_OUT = 1'b1
    } hs_dir_e;

    // Handshake control state
    typedef struct packed {
        logic    full;   // buffer holds a byte not yet consumed
        logic    ie;     // interrupt enable
        logic    intr;   // interrupt request
        hs_dir_e dir;    // direction the state belongs to
    } hs_ctrl_t;

    // Sampled strobe lanes
    localparam int HS_LANES   = 3;
    localparam int LANE_RD    = 0;
    localparam int LANE_WR    = 1;
    localparam int LANE_HS    = 2;

    // Status word bit positions
    localparam int STAT_W     = 3;
    localparam int ST_IE      = 2;
    localparam int ST_FLAG    = 1;
    localparam int ST_INTR    = 0;

endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;   // strobes idle high
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign rise[i] =  lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] &  prev_q[i];
    end

endmodule

// File: rtl/hs_data_latch.sv
module hs_data_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clr)     data_d = '0;
        else if (ld) data_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  hs_dir_e dir,
    input  logic    rd_rise,
    input  logic    rd_fall,
    input  logic    wr_rise,
    input  logic    wr_fall,
    input  logic    hs_rise,
    input  logic    hs_fall,
    input  logic    ie_set,
    input  logic    ie_clr,
    output logic    reinit,
    output logic    full,
    output logic    ie,
    output logic    intr,
    output hs_dir_e dir_q
);

    hs_ctrl_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reinit = (dir != st_q.dir);
        if (reinit) begin
            st_d      = '0;
            st_d.dir  = dir;
        end else begin
            if (ie_clr)      st_d.ie = 1'b0;
            else if (ie_set) st_d.ie = 1'b1;

            if (st_q.dir == HS_DIR_IN) begin
                if (hs_fall)      st_d.full = 1'b1;
                else if (rd_rise) st_d.full = 1'b0;
                if (rd_fall)
                    st_d.intr = 1'b0;
                else if (hs_rise && st_q.full && st_q.ie)
                    st_d.intr = 1'b1;
            end else begin
                if (wr_rise)      st_d.full = 1'b1;
                else if (hs_fall) st_d.full = 1'b0;
                if (wr_fall)
                    st_d.intr = 1'b0;
                else if (hs_rise && !st_q.full && st_q.ie)
                    st_d.intr = 1'b1;
            end

            if (!st_d.ie) st_d.intr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.full <= 1'b0;
            st_q.ie   <= 1'b0;
            st_q.intr <= 1'b0;
            st_q.dir  <= dir;
        end else begin
            st_q <= st_d;
        end
    end

    assign full  = st_q.full;
    assign ie    = st_q.ie;
    assign intr  = st_q.intr;
    assign dir_q = st_q.dir;

endmodule

// File: rtl/hs_port.sv
module hs_port
    import hs_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_out,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              per_hs_n,
    input  logic [DATA_W-1:0] per_din,
    output logic [DATA_W-1:0] per_dout,
    output logic              per_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              flag,
    output logic              intr,
    output logic [STAT_W-1:0] status
);

    hs_dir_e             dir;
    logic [HS_LANES-1:0] lvl, rise, fall;
    logic                reinit, full, ie, intr_w;
    hs_dir_e             dir_q;
    logic                rx_ld, tx_ld;

    assign dir = mode_out ? HS_DIR_OUT : HS_DIR_IN;

    always_comb begin
        lvl          = '1;
        lvl[LANE_RD] = cpu_rd_n;
        lvl[LANE_WR] = cpu_wr_n;
        lvl[LANE_HS] = per_hs_n;
    end

    hs_edge_det #(.N(HS_LANES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    hs_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir),
        .rd_rise (rise[LANE_RD]),
        .rd_fall (fall[LANE_RD]),
        .wr_rise (rise[LANE_WR]),
        .wr_fall (fall[LANE_WR]),
        .hs_rise (rise[LANE_HS]),
        .hs_fall (fall[LANE_HS]),
        .ie_set  (ie_set),
        .ie_clr  (ie_clr),
        .reinit  (reinit),
        .full    (full),
        .ie      (ie),
        .intr    (intr_w),
        .dir_q   (dir_q)
    );

    assign rx_ld = (dir == HS_DIR_IN)  && !per_hs_n;
    assign tx_ld = (dir == HS_DIR_OUT) && !cpu_wr_n;

    hs_data_latch #(.W(DATA_W)) u_rx_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reinit),
        .ld    (rx_ld),
        .din   (per_din),
        .dout  (rdata)
    );

    hs_data_latch #(.W(DATA_W)) u_tx_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reinit),
        .ld    (tx_ld),
        .din   (cpu_wdata),
        .dout  (per_dout)
    );

    assign per_oe = mode_out;
    assign flag   = (dir_q == HS_DIR_OUT) ? ~full : full;
    assign intr   = intr_w;

    always_comb begin
        status          = '0;
        status[ST_IE]   = ie;
        status[ST_FLAG] = flag;
        status[ST_INTR] = intr_w;
    end

endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_out,
    input logic       cpu_rd_n,
    input logic       cpu_wr_n,
    input logic       ie_clr,
    input logic       per_hs_n,
    input logic       flag,
    input logic       intr,
    input logic [2:0] status
);

    // R3
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out && $stable(mode_out) && $fell(per_hs_n)) |=> flag);

    // R6
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out && $stable(mode_out) && $rose(cpu_wr_n)) |=> !flag);

    // R4
    rd_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out && $fell(cpu_rd_n)) |=> !intr);

    // R7
    wr_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out && $fell(cpu_wr_n)) |=> !intr);

    // R8
    ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |=> (!intr && !status[2]));

    // R9
    intr_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> status[2]);

    // R10
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_out) |=> (!intr && !status[2] && (flag == mode_out)));

endmodule

bind hs_port hs_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_out (mode_out),
    .cpu_rd_n (cpu_rd_n),
    .cpu_wr_n (cpu_wr_n),
    .ie_clr   (ie_clr),
    .per_hs_n (per_hs_n),
    .flag     (flag),
    .intr     (intr),
    .status   (status)
);

// File: tb/hs_port_tb.sv
`timescale 1ns/1ps
module hs_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_out = 1'b0;
    logic       cpu_rd_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic [7:0] cpu_wdata = 8'h00;
    logic       ie_set = 1'b0;
    logic       ie_clr = 1'b0;
    logic       per_hs_n = 1'b1;
    logic [7:0] per_din = 8'h00;
    logic [7:0] per_dout;
    logic       per_oe;
    logic [7:0] rdata;
    logic       flag;
    logic       intr;
    logic [2:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hs_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_out(mode_out),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
        .ie_set(ie_set), .ie_clr(ie_clr), .per_hs_n(per_hs_n),
        .per_din(per_din), .per_dout(per_dout), .per_oe(per_oe),
        .rdata(rdata), .flag(flag), .intr(intr), .status(status)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    bit       m_dir, m_full, m_ie, m_intr;
    bit [7:0] m_rx, m_tx;
    bit       p_rd = 1, p_wr = 1, p_hs = 1;

    always @(posedge clk) begin
        bit of, oi;
        if (!rst_n) begin
            m_dir = mode_out; m_full = 0; m_ie = 0; m_intr = 0;
            m_rx = 0; m_tx = 0; p_rd = 1; p_wr = 1; p_hs = 1;
        end else begin
            of = m_full; oi = m_ie;
            if (mode_out != m_dir) begin
                m_dir = mode_out; m_full = 0; m_ie = 0; m_intr = 0;
                m_rx = 0; m_tx = 0;
            end else begin
                if (!m_dir && !per_hs_n) m_rx = per_din;
                if (m_dir && !cpu_wr_n)  m_tx = cpu_wdata;
                if (ie_clr) m_ie = 0; else if (ie_set) m_ie = 1;
                if (!m_dir) begin
                    if (p_hs && !per_hs_n) m_full = 1;
                    else if (!p_rd && cpu_rd_n) m_full = 0;
                    if (p_rd && !cpu_rd_n) m_intr = 0;
                    else if (!p_hs && per_hs_n && of && oi) m_intr = 1;
                end else begin
                    if (!p_wr && cpu_wr_n) m_full = 1;
                    else if (p_hs && !per_hs_n) m_full = 0;
                    if (p_wr && !cpu_wr_n) m_intr = 0;
                    else if (!p_hs && per_hs_n && !of && oi) m_intr = 1;
                end
                if (!m_ie) m_intr = 0;
            end
            p_rd = cpu_rd_n; p_wr = cpu_wr_n; p_hs = per_hs_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ef;
            ef = m_dir ? !m_full : m_full;
            chk("R2", "model rdata", rdata, m_rx);
            chk("R5", "model per_dout", per_dout, m_tx);
            chk("R5", "model per_oe", per_oe, mode_out);
            chk(m_dir ? "R6" : "R3", "model flag", flag, ef);
            chk(m_dir ? "R7" : "R4", "model intr", intr, m_intr);
            chk("R9", "model status", status, {m_ie, ef, m_intr});
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic summary;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(3);
        // R1 reset state, receive mode
        chk("R1", "flag", flag, 0); chk("R1", "intr", intr, 0);
        chk("R1", "status", status, 0); chk("R1", "rdata", rdata, 0);
        rst_n = 1; cyc(2);
        chk("R1", "flag after release", flag, 0);

        // R8 enable set
        ie_set = 1; cyc(); ie_set = 0;
        chk("R8", "ie set", status[2], 1);

        // R2/R3 strobe capture
        per_din = 8'hA5; per_hs_n = 0; cyc();
        chk("R3", "ibf rise", flag, 1);
        chk("R2", "rdata A5", rdata, 8'hA5);
        per_din = 8'h3C; cyc();
        chk("R2", "rdata 3C", rdata, 8'h3C);
        per_hs_n = 1; cyc();
        chk("R4", "intr rise", intr, 1);
        chk("R9", "status 111", status, 3'b111);
        per_din = 8'h77; cyc();
        chk("R2", "rdata held", rdata, 8'h3C);
        cpu_rd_n = 0; cyc();
        chk("R4", "intr clear on rd fall", intr, 0);
        chk("R3", "ibf held during rd", flag, 1);
        cpu_rd_n = 1; cyc();
        chk("R3", "ibf clear on rd rise", flag, 0);

        // R11 write ignored in receive mode
        cpu_wdata = 8'hEE; cpu_wr_n = 0; cyc(); cpu_wr_n = 1; cyc();
        chk("R11", "per_dout untouched", per_dout, 0);
        chk("R11", "flag untouched", flag, 0);

        // R8 no interrupt when enable clear, flag keeps working
        ie_clr = 1; cyc(); ie_clr = 0;
        per_hs_n = 0; cyc(); per_hs_n = 1; cyc(2);
        chk("R8", "flag with ie clear", flag, 1);
        chk("R8", "no intr with ie clear", intr, 0);
        cpu_rd_n = 0; cyc(); cpu_rd_n = 1; cyc();
        // R8 clear forces intr low at once
        ie_set = 1; cyc(); ie_set = 0;
        per_hs_n = 0; cyc(); per_hs_n = 1; cyc();
        chk("R4", "intr up again", intr, 1);
        ie_clr = 1; cyc(); ie_clr = 0;
        chk("R8", "intr dropped with ie", intr, 0);
        chk("R8", "flag kept", flag, 1);

        // R10 mode change reinitialises
        mode_out = 1; #1;
        chk("R5", "per_oe immediate", per_oe, 1);
        cyc();
        chk("R10", "flag idle transmit", flag, 1);
        chk("R10", "rdata cleared", rdata, 0);
        chk("R10", "status", status, 3'b010);

        // Transmit handshake
        ie_set = 1; cyc(); ie_set = 0;
        cpu_wdata = 8'h5A; cpu_wr_n = 0; cyc();
        chk("R5", "per_dout 5A", per_dout, 8'h5A);
        chk("R6", "obf not yet", flag, 1);
        cpu_wr_n = 1; cyc();
        chk("R6", "obf low after wr rise", flag, 0);
        // R11 read ignored in transmit mode
        cpu_rd_n = 0; cyc(); cpu_rd_n = 1; cyc();
        chk("R11", "flag untouched by rd", flag, 0);
        chk("R11", "intr untouched by rd", intr, 0);
        per_hs_n = 0; cyc();
        chk("R6", "obf high on ack fall", flag, 1);
        per_hs_n = 1; cyc();
        chk("R7", "intr on ack rise", intr, 1);
        cpu_wdata = 8'hC3; cpu_wr_n = 0; cyc();
        chk("R7", "intr clear on wr fall", intr, 0);
        cpu_wr_n = 1; cyc();
        chk("R5", "per_dout C3", per_dout, 8'hC3);

        // R8 transmit with enable clear
        ie_clr = 1; cyc(); ie_clr = 0;
        per_hs_n = 0; cyc(); per_hs_n = 1; cyc(2);
        chk("R8", "no transmit intr", intr, 0);
        chk("R6", "obf released", flag, 1);

        // R1 reset during operation
        cpu_wr_n = 0; cyc(); cpu_wr_n = 1;
        rst_n = 0; cyc(2);
        chk("R1", "per_dout reset", per_dout, 0);
        chk("R1", "flag idle transmit", flag, 1);
        chk("R1", "status reset", status, 3'b010);
        rst_n = 1; cyc(3);
        summary();
    end

endmodule